// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Routing

This block is the interrupt register group of a memory-mapped serial port. It keeps an eleven-bit raw status vector that is set by single-cycle event pulses from the receive FIFO, the transmitter, the modem-status logic, a receive-timeout detector and the error detectors. Software programs an enable mask, reads back the raw and masked status, and acknowledges events by writing ones to a write-only clear register.

From the masked status the block drives six registered level outputs. Five of them each follow one group of sources: receive, transmit, receive timeout, modem status and error. The sixth is the combined line, which is the OR of all five. A write to the data register offset also sets the transmit bit, so that the data path does not need to raise a separate pulse for each byte it accepts.

Register offsets are word indices on `reg_addr`: 0 data, 1 enable mask, 2 raw status, 3 masked status, 4 clear. Reads of the data offset and of unmapped offsets return zero.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While and after reset, the raw status, the enable mask and all six interrupt outputs are zero.
- R2: A write to offset 1 loads bits 10:0 of the write data into the enable mask, and a read of offset 1 returns the mask with bits above 10 reading as zero.
- R3: A read of offset 2 returns the raw status vector, and a read of offset 3 returns raw status AND enable mask.
- R4: A write to offset 4 clears every raw bit whose position is one in the write data and leaves the others unchanged; a read of offset 4 returns zero.
- R5: Writes to offsets 2 and 3 change neither the raw status nor the enable mask.
- R6: Every write to offset 0 sets the transmit raw bit (bit 5).
- R7: Event pulses set raw bits at fixed positions: modem inputs `ev_ms[3:0]` set bits 3:0 (ring, clear-to-send, carrier, data-set-ready), `ev_rx` bit 4, `ev_tx` bit 5, `ev_rt` bit 6, `ev_err[3:0]` bits 10:7.
- R8: When an event pulse and a clear write hit the same raw bit in one cycle, the bit ends up set.
- R9: `irq_rx`, `irq_tx` and `irq_rt` follow masked bits 4, 5 and 6; `irq_ms` is high when any masked bit of 3:0 is set; `irq_err` is high when any masked bit of 10:7 is set.
- R10: `irq_comb` is high exactly when any masked bit is set.
- R11: The outputs are registered: they reflect the raw status and mask held in the previous cycle, one clock edge after a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| ev_ms | input | 4 | Modem-status change pulses |
| ev_rx | input | 1 | Receive level-reached pulse |
| ev_tx | input | 1 | Transmit space pulse |
| ev_rt | input | 1 | Receive timeout pulse |
| ev_err | input | 4 | Error pulses |
| irq_comb | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive timeout interrupt |
| irq_ms | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The checker compares every output against the masked status of the previous cycle, confirms that pulses and data writes leave their raw bit set, that a clear write with no competing pulse leaves its bits clear, that the mask holds without a write, and that the clear offset reads zero. What only the directed scenarios show is the bit placement of each pulse, the read-back of each offset, that writes to the status offsets are ignored, and the set-over-clear collision as seen from software.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NB    = 11;
   localparam int NGRP  = 5;
   typedef logic [NB-1:0] ivec_t;

   localparam int OFF_DATA   = 0;
   localparam int OFF_MASK   = 1;
   localparam int OFF_RAW    = 2;
   localparam int OFF_MASKED = 3;
   localparam int OFF_CLEAR  = 4;

   localparam ivec_t GRP_RX  = 11'h010;
   localparam ivec_t GRP_TX  = 11'h020;
   localparam ivec_t GRP_RT  = 11'h040;
   localparam ivec_t GRP_MS  = 11'h00F;
   localparam ivec_t GRP_ERR = 11'h780;

   // routing order of the per-group outputs
   localparam ivec_t GRP_MASK [0:NGRP-1] = '{GRP_RX, GRP_TX, GRP_RT, GRP_MS, GRP_ERR};
endpackage

// File: rtl/uic_mask_reg.sv
module uic_mask_reg
   import uart_irq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  ivec_t din,
   output ivec_t mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask <= '0;
      else if (load) mask <= din;
   end
endmodule

// File: rtl/uic_raw_status.sv
module uic_raw_status
   import uart_irq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  ivec_t set_vec,
   input  ivec_t clr_vec,
   output ivec_t raw
);
   // a set arriving with a clear on the same bit wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw <= '0;
      else        raw <= (raw & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/uic_route.sv
module uic_route
   import uart_irq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  ivec_t           masked,
   output logic [NGRP-1:0] irq_grp,
   output logic            irq_all
);
   for (genvar g = 0; g < NGRP; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_grp[g] <= 1'b0;
         else        irq_grp[g] <= |(masked & GRP_MASK[g]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_all <= 1'b0;
      else        irq_all <= |masked;
   end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [3:0]        ev_ms,
   input  logic              ev_rx,
   input  logic              ev_tx,
   input  logic              ev_rt,
   input  logic [3:0]        ev_err,
   output logic              irq_comb,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_rt,
   output logic              irq_ms,
   output logic              irq_err
);
   if (DATA_W < NB) begin : g_bad_data_w
      $error("DATA_W must hold the status vector");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("ADDR_W must reach offset 4");
   end

   logic  hit_data, hit_mask, hit_raw, hit_masked, hit_clear;
   ivec_t raw_q, mask_q, masked, set_vec, clr_vec;
   logic [NGRP-1:0] grp_q;
   logic  unused_wdata;

   assign hit_data   = reg_addr == ADDR_W'(OFF_DATA);
   assign hit_mask   = reg_addr == ADDR_W'(OFF_MASK);
   assign hit_raw    = reg_addr == ADDR_W'(OFF_RAW);
   assign hit_masked = reg_addr == ADDR_W'(OFF_MASKED);
   assign hit_clear  = reg_addr == ADDR_W'(OFF_CLEAR);

   assign unused_wdata = ^reg_wdata[DATA_W-1:NB];

   assign set_vec = {ev_err, ev_rt, ev_tx | (reg_wr & hit_data), ev_rx, ev_ms};
   assign clr_vec = (reg_wr && hit_clear) ? reg_wdata[NB-1:0] : '0;
   assign masked  = raw_q & mask_q;

   uic_mask_reg u_mask (
      .clk (clk), .rst_n (rst_n),
      .load (reg_wr & hit_mask), .din (reg_wdata[NB-1:0]),
      .mask (mask_q)
   );

   uic_raw_status u_raw (
      .clk (clk), .rst_n (rst_n),
      .set_vec (set_vec), .clr_vec (clr_vec),
      .raw (raw_q)
   );

   uic_route u_route (
      .clk (clk), .rst_n (rst_n),
      .masked (masked), .irq_grp (grp_q), .irq_all (irq_comb)
   );

   assign irq_rx  = grp_q[0];
   assign irq_tx  = grp_q[1];
   assign irq_rt  = grp_q[2];
   assign irq_ms  = grp_q[3];
   assign irq_err = grp_q[4];

   always_comb begin
      reg_rdata = '0;
      if (hit_mask)        reg_rdata = DATA_W'(mask_q);
      else if (hit_raw)    reg_rdata = DATA_W'(raw_q);
      else if (hit_masked) reg_rdata = DATA_W'(masked);
   end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [NB-1:0]     wlow,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [3:0]        ev_ms,
   input logic              ev_rx,
   input logic              ev_tx,
   input logic              ev_rt,
   input logic [3:0]        ev_err,
   input logic [NB-1:0]     raw_q,
   input logic [NB-1:0]     mask_q,
   input logic              irq_comb,
   input logic              irq_rx,
   input logic              irq_tx,
   input logic              irq_rt,
   input logic              irq_ms,
   input logic              irq_err
);
   logic no_ev;
   assign no_ev = (ev_ms == 4'h0) && !ev_rx && !ev_tx && !ev_rt && (ev_err == 4'h0);

   p_comb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_comb == $past(|(raw_q & mask_q)));
   p_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_rx == $past(raw_q[4] & mask_q[4]));
   p_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_tx == $past(raw_q[5] & mask_q[5]));
   p_rt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_rt == $past(raw_q[6] & mask_q[6]));
   p_ms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_ms == $past(|(raw_q[3:0] & mask_q[3:0])));
   p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_err == $past(|(raw_q[10:7] & mask_q[10:7])));
   p_rx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx |=> raw_q[4]);
   p_data_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFF_DATA)) |=> raw_q[5]);
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFF_CLEAR) && no_ev) |=> (raw_q & $past(wlow)) == '0);
   p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == ADDR_W'(OFF_MASK)) |=> $stable(mask_q));

   always_comb begin
      if (rst_n && reg_addr == ADDR_W'(OFF_CLEAR))
         p_clear_reads_zero_r4: assert (reg_rdata == '0);
   end
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
   .wlow (reg_wdata[10:0]), .reg_rdata (reg_rdata),
   .ev_ms (ev_ms), .ev_rx (ev_rx), .ev_tx (ev_tx), .ev_rt (ev_rt), .ev_err (ev_err),
   .raw_q (raw_q), .mask_q (mask_q),
   .irq_comb (irq_comb), .irq_rx (irq_rx), .irq_tx (irq_tx), .irq_rt (irq_rt),
   .irq_ms (irq_ms), .irq_err (irq_err)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
   localparam int AW = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [3:0]    ev_ms = '0;
   logic          ev_rx = 1'b0, ev_tx = 1'b0, ev_rt = 1'b0;
   logic [3:0]    ev_err = '0;
   logic irq_comb, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

   int checks = 0;
   int failures = 0;
   logic [10:0] m_raw = '0, m_mask = '0;

   always #5 clk = ~clk;

   uart_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .ev_ms (ev_ms), .ev_rx (ev_rx), .ev_tx (ev_tx), .ev_rt (ev_rt), .ev_err (ev_err),
      .irq_comb (irq_comb), .irq_rx (irq_rx), .irq_tx (irq_tx), .irq_rt (irq_rt),
      .irq_ms (irq_ms), .irq_err (irq_err)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = AW'(a);
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [10:0] v);
      @(negedge clk);
      {ev_err, ev_rt, ev_tx, ev_rx, ev_ms} = v;
      @(negedge clk);
      {ev_err, ev_rt, ev_tx, ev_rx, ev_ms} = '0;
   endtask

   function automatic logic [5:0] exp_irq();
      logic [10:0] m;
      m = m_raw & m_mask;
      return {|m, m[4], m[5], m[6], |m[3:0], |m[10:7]};
   endfunction

   task automatic chk_out(input string tag);
      chk(tag, 32'({irq_comb, irq_rx, irq_tx, irq_rt, irq_ms, irq_err}), 32'(exp_irq()));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(1, d); chk("R1 mask after reset", d, 0);
      rd(2, d); chk("R1 raw after reset", d, 0);
      chk_out("R1 outputs after reset");
   endtask

   task automatic t_mask_rw();
      logic [31:0] d;
      wr(1, 32'hFFFF_FFFF); m_mask = 11'h7FF;
      rd(1, d); chk("R2 mask readback upper zero", d, 32'h7FF);
      wr(1, 32'h0000_0155); m_mask = 11'h155;
      rd(1, d); chk("R2 mask pattern", d, 32'h155);
      wr(1, 0); m_mask = '0;
   endtask

   task automatic t_events();
      logic [31:0] d;
      wr(1, 32'h7FF); m_mask = 11'h7FF;
      @(negedge clk);
      pulse(11'b0000_000_0101); m_raw |= 11'h005;
      rd(2, d); chk("R7 modem bits", d, 32'h005);
      chk("R11 output lags one cycle", 32'(irq_comb), 0);
      @(negedge clk);
      chk_out("R9 R10 modem group after one edge");
      pulse(11'h010); m_raw |= 11'h010;
      pulse(11'h020); m_raw |= 11'h020;
      pulse(11'h040); m_raw |= 11'h040;
      pulse(11'h500); m_raw |= 11'h500;
      rd(2, d); chk("R7 all groups raw", d, 32'h575);
      @(negedge clk);
      chk_out("R9 all groups routed");
   endtask

   task automatic t_routing();
      logic [31:0] d;
      wr(1, 32'h020); m_mask = 11'h020;
      rd(3, d); chk("R3 masked read", d, 32'(m_raw & m_mask));
      rd(2, d); chk("R3 raw read ignores mask", d, 32'(m_raw));
      @(negedge clk);
      chk_out("R9 only transmit line");
      wr(1, 32'h780); m_mask = 11'h780;
      @(negedge clk);
      chk_out("R9 error group only");
      wr(1, 0); m_mask = '0;
      @(negedge clk);
      chk_out("R10 all masked off");
   endtask

   task automatic t_clear();
      logic [31:0] d;
      wr(1, 32'h010); m_mask = 11'h010;
      @(negedge clk);
      wr(4, 32'h0000_001F); m_raw &= ~11'h01F;
      rd(2, d); chk("R4 clear selected bits", d, 32'(m_raw));
      chk("R11 rx line still high one cycle", 32'(irq_rx), 1);
      @(negedge clk);
      chk("R11 rx line low after clear", 32'(irq_rx), 0);
      rd(4, d); chk("R4 clear reads zero", d, 0);
   endtask

   task automatic t_ignored();
      logic [31:0] d;
      wr(2, 32'h7FF);
      wr(3, 32'h000);
      rd(2, d); chk("R5 raw unchanged by status writes", d, 32'(m_raw));
      rd(1, d); chk("R5 mask unchanged by status writes", d, 32'(m_mask));
   endtask

   task automatic t_data();
      logic [31:0] d;
      wr(4, 32'h7FF); m_raw = '0;
      wr(0, 32'h41); m_raw |= 11'h020;
      rd(2, d); chk("R6 data write sets transmit bit", d, 32'h020);
      rd(0, d); chk("R6 data offset reads zero", d, 0);
   endtask

   task automatic t_set_over_clear();
      logic [31:0] d;
      wr(4, 32'h7FF); m_raw = '0;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(4); reg_wdata = 32'h010; ev_rx = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; ev_rx = 1'b0; m_raw = 11'h010;
      rd(2, d); chk("R8 set wins over clear", d, 32'h010);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask_rw();
      t_events();
      t_routing();
      t_clear();
      t_ignored();
      t_data();
      t_set_over_clear();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule